// File: doc/BRIEF.md
# Bitmap Pixel Fetcher

This block turns a linear framebuffer of 16-bit words into a stream of 8-bit palette indices, one per clock while the raster is in the visible region. Two configuration registers hold a control word (display enable, pixel depth and the top bits of the frame address) and the low 16 bits of the frame start byte address. The block reads video RAM through a word read port with one clock of latency and keeps a small word buffer ahead of the raster, so no gaps appear at word boundaries.

The raster timing comes from outside as an x/y position and an active flag. The visible region of every line must start at x = 0 and be contiguous, and each line needs at least three inactive clocks after its visible part; the buffer refills for the next line during them. The end of the visible part of the last visible line is the frame reload point: the configuration registers are copied into the working state there, and the next frame starts from the new address. Palette lookup, colour output and timing generation are done by other blocks.

Top module: `bmp_pixel_fetch`

## Requirements
- R1: During and right after reset, `pix_idx` is 0 and `mem_req` is low.
- R2: When control bit 15 (display enable) is 0 in the working state, every output index is 0 and `mem_req` stays low.
- R3: With control bit 7 = 1 (4 bits per pixel), each word gives four pixels, left to right from bits 15:12, 11:8, 7:4 and 3:0, and each pixel is output zero-extended to 8 bits.
- R4: With control bit 7 = 0 (8 bits per pixel), each word gives two pixels: bits 15:8 first, then bits 7:0.
- R5: The first pixel of a frame comes from word address {control[3:0], start[15:0]} shifted right by one (a 20-bit byte address halved; start bit 0 is dropped).
- R6: Visible line n of a frame begins at the frame word address plus n times 84 (4 bpp) or n times 168 (8 bpp), however many of those words are shown.
- R7: While `ras_active` is low the output index is 0 and the fetch position within the line does not advance.
- R8: Register writes change nothing until the reload point (end of the visible part of line V_VIS-1); the frame after it uses the new enable, depth and address.
- R9: Each active clock produces exactly one pixel, its index appearing on `pix_idx` one clock after the raster position, with no stall at word boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control register, 1 the start-address register |
| cfg_wdata | input | 16 | Configuration write data |
| ras_x | input | X_W | Raster column |
| ras_y | input | Y_W | Raster line |
| ras_active | input | 1 | Raster is inside the visible region |
| mem_req | output | 1 | Video RAM read request |
| mem_addr | output | BYTE_ADDR_W-1 | Video RAM word address |
| mem_rdata | input | 16 | Read data, valid the clock after the request |
| pix_idx | output | 8 | Palette index for the previous clock's raster position |

## Verification
Each palette index is due on the clock after its raster position was presented, and read data is returned by the bench memory one clock after the request, so the expected stream is built purely from the raster the bench drives. The driver presents a position on the falling edge and queues its expected index; the monitor samples two nanoseconds after the next rising edge and pops exactly one item, which keeps every comparison aligned to that single cycle of latency. Configuration changes are modelled as taking effect at the reload position the driver itself emits, so the frames before and after a mid-frame write check that the change is deferred.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
   localparam int WORD_W    = 16;
   localparam int PIX_W     = 8;
   localparam int EN_BIT    = 15;
   localparam int DEPTH_BIT = 7;
   localparam int NIB_W     = 4;
   localparam int BYTE_W    = 8;

   typedef enum logic {
      DEPTH_8BPP = 1'b0,
      DEPTH_4BPP = 1'b1
   } depth_e;

   typedef struct packed {
      logic   enable;
      depth_e depth;
   } mode_t;
endpackage

// File: rtl/bpf_cfg_regs.sv
module bpf_cfg_regs
   import bpf_pkg::*;
#(
   parameter int BYTE_ADDR_W = 20,
   localparam int WADDR_W    = BYTE_ADDR_W - 1,
   localparam int HI_W       = BYTE_ADDR_W - WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic               load,
   output mode_t              mode,
   output logic [WADDR_W-1:0] next_base
);
   generate
      if (HI_W < 1 || HI_W > 4) begin : g_bad_addr_w
         $error("BYTE_ADDR_W must lie between 17 and 20");
      end
   endgenerate

   logic [WORD_W-1:0] ctrl_q;
   logic [WORD_W-1:0] start_q;
   mode_t             mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         start_q <= '0;
      end else if (wr_en) begin
         if (wr_sel) start_q <= wr_data;
         else        ctrl_q  <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '{enable: 1'b0, depth: DEPTH_8BPP};
      end else if (load) begin
         mode_q.enable <= ctrl_q[EN_BIT];
         mode_q.depth  <= depth_e'(ctrl_q[DEPTH_BIT]);
      end
   end

   assign mode      = mode_q;
   assign next_base = {ctrl_q[HI_W-1:0], start_q[WORD_W-1:1]};

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{ctrl_q[EN_BIT-1:DEPTH_BIT+1], ctrl_q[DEPTH_BIT-1:HI_W], start_q[0]};

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mode_q)); // R8
endmodule

// File: rtl/bpf_line_addr.sv
module bpf_line_addr #(
   parameter int WADDR_W     = 19,
   parameter int WORDS_4BPP  = 84,
   parameter int WORDS_8BPP  = 168
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_end,
   input  logic               reload,
   input  logic [WADDR_W-1:0] reload_base,
   input  logic               depth4,
   input  logic               req,
   output logic [WADDR_W-1:0] fetch_addr
);
   localparam logic [WADDR_W-1:0] STEP4 = WADDR_W'(WORDS_4BPP);
   localparam logic [WADDR_W-1:0] STEP8 = WADDR_W'(WORDS_8BPP);

   logic [WADDR_W-1:0] line_q;
   logic [WADDR_W-1:0] fetch_q;
   logic [WADDR_W-1:0] step;
   logic [WADDR_W-1:0] next_line;

   assign step      = depth4 ? STEP4 : STEP8;
   assign next_line = reload ? reload_base : line_q + step;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         fetch_q <= '0;
      end else if (line_end) begin
         line_q  <= next_line;
         fetch_q <= next_line;
      end else if (req) begin
         fetch_q <= fetch_q + 1'b1;
      end
   end

   assign fetch_addr = fetch_q;

   AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !line_end) |=> fetch_q == $past(fetch_q) + 1'b1); // R6
   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_end |=> $stable(line_q)); // R7
endmodule

// File: rtl/bpf_word_buf.sv
module bpf_word_buf
   import bpf_pkg::*;
#(
   parameter int DEPTH  = 2,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              enable,
   input  logic              pop,
   input  logic [WORD_W-1:0] rdata,
   output logic              req,
   output logic              has_word,
   output logic [WORD_W-1:0] head
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("word buffer needs at least two entries");
      end
   endgenerate

   logic [WORD_W-1:0] ent_q [DEPTH];
   logic [WORD_W-1:0] ent_n [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              pend_q;
   logic [CNT_W-1:0]  wr_idx;
   logic [CNT_W:0]    occ;
   logic [CNT_W:0]    limit;

   assign wr_idx = cnt_q - CNT_W'(pop);
   assign occ    = {1'b0, cnt_q} + (CNT_W+1)'(pend_q);
   assign limit  = (CNT_W+1)'(DEPTH - 1) + (CNT_W+1)'(pop);
   assign req    = enable && !flush && (occ <= limit);

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         ent_n[i] = ent_q[i];
         if (pop && i < DEPTH - 1) ent_n[i] = ent_q[i+1];
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (pend_q && CNT_W'(i) == wr_idx) ent_n[i] = rdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else if (flush) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= req;
         cnt_q  <= cnt_q + CNT_W'(pend_q) - CNT_W'(pop);
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
      end
   end

   assign has_word = (cnt_q != '0);
   assign head     = ent_q[0];

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt_q != '0); // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !pop && !flush) |-> cnt_q < CNT_W'(DEPTH)); // R9
endmodule

// File: rtl/bpf_pix_sel.sv
module bpf_pix_sel
   import bpf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              active,
   input  logic              enable,
   input  logic              depth4,
   input  logic              has_word,
   input  logic [WORD_W-1:0] head,
   output logic              pop,
   output logic [PIX_W-1:0]  pix
);
   localparam int NIB_LANES  = WORD_W / NIB_W;
   localparam int BYTE_LANES = WORD_W / BYTE_W;
   localparam int SUB_W      = $clog2(NIB_LANES);

   logic [NIB_W-1:0]  nib [NIB_LANES];
   logic [BYTE_W-1:0] byt [BYTE_LANES];

   genvar g;
   generate
      for (g = 0; g < NIB_LANES; g++) begin : g_nib
         assign nib[g] = head[WORD_W-1-g*NIB_W -: NIB_W];
      end
      for (g = 0; g < BYTE_LANES; g++) begin : g_byte
         assign byt[g] = head[WORD_W-1-g*BYTE_W -: BYTE_W];
      end
   endgenerate

   logic [SUB_W-1:0] sub_q;
   logic [SUB_W-1:0] last;
   logic [PIX_W-1:0] sel;
   logic             step;
   logic [PIX_W-1:0] pix_q;

   assign last = depth4 ? SUB_W'(NIB_LANES - 1) : SUB_W'(BYTE_LANES - 1);
   assign step = active && enable;
   assign pop  = step && (sub_q == last);
   assign sel  = depth4 ? PIX_W'(nib[sub_q]) : byt[sub_q[0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_q <= '0;
         pix_q <= '0;
      end else begin
         if (flush)     sub_q <= '0;
         else if (pop)  sub_q <= '0;
         else if (step) sub_q <= sub_q + 1'b1;
         pix_q <= (step && has_word) ? sel : '0;
      end
   end

   assign pix = pix_q;

   AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> pix_q == '0); // R7
   AST_WORD_READY: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> has_word); // R9
endmodule

// File: rtl/bmp_pixel_fetch.sv
module bmp_pixel_fetch
   import bpf_pkg::*;
#(
   parameter int BYTE_ADDR_W = 20,
   parameter int WORDS_4BPP  = 84,
   parameter int WORDS_8BPP  = 168,
   parameter int H_VIS       = 320,
   parameter int V_VIS       = 256,
   parameter int X_W         = 9,
   parameter int Y_W         = 9,
   parameter int BUF_DEPTH   = 2,
   localparam int WADDR_W    = BYTE_ADDR_W - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [15:0]        cfg_wdata,
   input  logic [X_W-1:0]     ras_x,
   input  logic [Y_W-1:0]     ras_y,
   input  logic               ras_active,
   output logic               mem_req,
   output logic [WADDR_W-1:0] mem_addr,
   input  logic [15:0]        mem_rdata,
   output logic [7:0]         pix_idx
);
   generate
      if (H_VIS > 4 * WORDS_4BPP || H_VIS > 2 * WORDS_8BPP) begin : g_bad_width
         $error("visible width exceeds the words fetched per line");
      end
      if (H_VIS >= (1 << X_W) || V_VIS > (1 << Y_W) || V_VIS < 1) begin : g_bad_raster
         $error("raster size does not fit the position inputs");
      end
   endgenerate

   logic               active_d;
   logic               line_end;
   logic               reload;
   mode_t              mode;
   logic [WADDR_W-1:0] next_base;
   logic               req;
   logic               pop;
   logic               has_word;
   logic [WORD_W-1:0]  head;

   always_ff @(posedge clk) begin
      if (!rst_n) active_d <= 1'b0;
      else        active_d <= ras_active;
   end

   assign line_end = active_d && !ras_active;
   assign reload   = line_end && (ras_y == Y_W'(V_VIS - 1));

   bpf_cfg_regs #(.BYTE_ADDR_W(BYTE_ADDR_W)) cfg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .load      (reload),
      .mode      (mode),
      .next_base (next_base)
   );

   bpf_line_addr #(
      .WADDR_W    (WADDR_W),
      .WORDS_4BPP (WORDS_4BPP),
      .WORDS_8BPP (WORDS_8BPP)
   ) addr_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_end    (line_end),
      .reload      (reload),
      .reload_base (next_base),
      .depth4      (mode.depth == DEPTH_4BPP),
      .req         (req),
      .fetch_addr  (mem_addr)
   );

   bpf_word_buf #(.DEPTH(BUF_DEPTH)) buf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (line_end),
      .enable   (mode.enable),
      .pop      (pop),
      .rdata    (mem_rdata),
      .req      (req),
      .has_word (has_word),
      .head     (head)
   );

   bpf_pix_sel sel_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (line_end),
      .active   (ras_active),
      .enable   (mode.enable),
      .depth4   (mode.depth == DEPTH_4BPP),
      .has_word (has_word),
      .head     (head),
      .pop      (pop),
      .pix      (pix_idx)
   );

   assign mem_req = req;

   AST_OFF_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      !mode.enable |-> !mem_req); // R2
   AST_OFF_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !mode.enable |=> pix_idx == '0); // R2
   AST_X_IN_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      ras_active |-> ras_x < X_W'(H_VIS)); // R9
endmodule

// File: tb/bmp_pixel_fetch_tb_top.sv
module bmp_pixel_fetch_tb_top;
   localparam int H_VIS = 8;
   localparam int V_VIS = 3;
   localparam int H_TOT = 12;
   localparam int V_TOT = 5;
   localparam int AW    = 19;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [8:0]  ras_x = '0;
   logic [8:0]  ras_y = '0;
   logic        ras_active = 1'b0;
   logic        mem_req;
   logic [AW-1:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic [7:0]  pix_idx;

   int checks = 0;
   int failures = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   // bench model of live and working configuration
   logic [15:0] live_ctrl = '0;
   logic [15:0] live_start = '0;
   logic        m_en = 1'b0;
   logic        m_4bpp = 1'b0;
   int          m_base = 0;
   logic        pend_wr = 1'b0;

   always #4 clk = ~clk;

   bmp_pixel_fetch #(.H_VIS(H_VIS), .V_VIS(V_VIS)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ras_x(ras_x), .ras_y(ras_y),
      .ras_active(ras_active), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .pix_idx(pix_idx)
   );

   function automatic logic [15:0] ram_word(input int a);
      logic [18:0] w;
      w = a[18:0];
      return (w[15:0] * 16'd40503) ^ {13'd0, w[18:16]} ^ 16'hA5C3;
   endfunction

   always @(posedge clk) mem_rdata <= ram_word(int'(mem_addr));

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // monitor: one expected item per cycle, sampled after the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {8'h00, pix_idx}, {8'h00, e});
            if (!m_en) check("R2 mem_req", {15'd0, mem_req}, 16'd0);
         end
      end
   end

   task automatic run_frame(input logic do_wr, input logic [15:0] ctrl, input logic [15:0] start);
      for (int y = 0; y < V_TOT; y++) begin
         for (int x = 0; x < H_TOT; x++) begin
            logic       act;
            int         ppw;
            int         wa;
            logic [15:0] w;
            logic [7:0] e;
            string      t;
            @(negedge clk);
            act = (x < H_VIS) && (y < V_VIS);
            ras_x = 9'(x);
            ras_y = 9'(y);
            ras_active = act;
            cfg_we = 1'b0;
            if (do_wr && y == 1 && x == 2) begin
               cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = ctrl;
               live_ctrl = ctrl; pend_wr = 1'b1;
            end
            if (do_wr && y == 1 && x == 3) begin
               cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = start;
               live_start = start;
            end
            if (x == H_VIS && y == V_VIS - 1) begin
               m_en    = live_ctrl[15];
               m_4bpp  = live_ctrl[7];
               m_base  = int'({live_ctrl[3:0], live_start[15:1]});
               pend_wr = 1'b0;
            end
            ppw = m_4bpp ? 4 : 2;
            e = 8'h00;
            if (act && m_en) begin
               wa = (m_base + y * (m_4bpp ? 84 : 168) + x / ppw) % (1 << AW);
               w  = ram_word(wa);
               if (m_4bpp) e = {4'h0, w[15 - 4*(x%4) -: 4]};
               else        e = w[15 - 8*(x%2) -: 8];
            end
            if (!act)                  t = "R7";
            else if (!m_en)            t = "R2";
            else if (pend_wr)          t = "R8";
            else if (x == 0 && y == 0) t = "R5";
            else if (x == 0)           t = "R6";
            else if (x % ppw == 0)     t = "R9";
            else if (m_4bpp)           t = "R3";
            else                       t = "R4";
            exp_q.push_back(e);
            tag_q.push_back(t);
         end
      end
   endtask

   initial begin
      fork
         begin
            repeat (200000) @(posedge clk);
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      check("R1 pix", {8'h00, pix_idx}, 16'd0);
      check("R1 mem_req", {15'd0, mem_req}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pix after reset", {8'h00, pix_idx}, 16'd0);
      check("R1 mem_req after reset", {15'd0, mem_req}, 16'd0);
      // frame 0: disabled; schedule enable, 4 bpp, byte address 0x31235
      run_frame(1'b1, 16'h8083, 16'h1235);
      // frame 1: 4 bpp; schedule 8 bpp at byte address 0xAFFFE
      run_frame(1'b1, 16'h800A, 16'hFFFE);
      // frame 2: 8 bpp; schedule display off
      run_frame(1'b1, 16'h0085, 16'h4444);
      // frame 3: off; schedule 8 bpp again with an odd start byte
      run_frame(1'b1, 16'h8001, 16'h0101);
      run_frame(1'b0, 16'h0000, 16'h0000);
      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule